// File: doc/BRIEF.md
# Cascadable Presettable Up/Down Counter

This block is a 4-bit binary counter slice that steps up or down on the rising clock edge when its active-low carry-in is asserted. It can be cleared or parallel-loaded from a 4-bit jam value at any moment, without waiting for a clock. Each slice drives an active-low carry-out that flags its terminal count for the current direction, so identical slices can share one clock and be chained: each slice's carry-out feeds the carry-in of the slice above it.

The top module is a parameterised chain of such slices. With the default three slices it behaves as one synchronous 12-bit up/down counter. The carry ripples through the slices combinationally within the cycle, and every slice updates on the same edge.

Top module: `updn_cascade`

## Requirements
- R1: While `clear` is high, `count` is zero. Clear acts at once, without a clock edge, and it overrides `load`, the clock and carry-in.
- R2: A rising `load`, with `clear` low, copies `jam` into `count` without waiting for a clock edge. Any clock edge that arrives while `load` is still high keeps `count` equal to `jam`.
- R3: With `clear` and `load` low and `cin_n` high, `count` holds its value across clock edges.
- R4: With `clear` and `load` low, `cin_n` low and `up` high (1 = up), `count` increases by one on each rising clock edge.
- R5: With `clear` and `load` low, `cin_n` low and `up` low (0 = down), `count` decreases by one on each rising clock edge.
- R6: Counting wraps. Each 4-bit slice goes from 15 to 0 when counting up and from 0 to 15 when counting down. The whole chain wraps from all-ones to zero, and from zero to all-ones.
- R7: `cout_n` is low exactly when `cin_n` is low and `count` is at its terminal value: all ones when `up` is 1, all zeros when `up` is 0. It follows changes of `cin_n` and `up` within the same cycle, with no clock edge needed.
- R8: Slices in the chain update together on the shared clock edge. A slice advances only on an edge where every lower slice sits at its terminal value for the current direction, so carries and borrows cross slice boundaries in a single cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock; counting happens on the rising edge |
| clear | input | 1 | Asynchronous clear, active high, highest priority |
| load | input | 1 | Asynchronous parallel load of `jam`, active high |
| cin_n | input | 1 | Count enable of the lowest slice, active low |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| jam | input | 4*STAGES | Parallel load value |
| count | output | 4*STAGES | Current count |
| cout_n | output | 1 | Terminal-count carry-out of the top slice, active low |

## Verification
A clocked step (R3 to R6, R8) shows on `count` one edge after the inputs that enable it. The bench changes inputs 2 ns after a rising edge and compares against its integer model at the following falling edge. Clear and load (R1, R2) take effect without any edge, so they are raised mid-cycle and checked in the same half-cycle, before any edge can mask them. `cout_n` (R7) is purely combinational, so it is checked 1 ns after each change of `cin_n` or `up`, including direction flips while the counter sits at all-ones or all-zeros.

// File: rtl/updn_pkg.sv
package updn_pkg;
  localparam int SLICE_BITS = 4;
  typedef logic [SLICE_BITS-1:0] slice_t;

  // one step in the selected direction, modulo 2**SLICE_BITS
  function automatic slice_t slice_step(input slice_t v, input logic dir_up);
    return dir_up ? slice_t'(v + 1'b1) : slice_t'(v - 1'b1);
  endfunction

  // terminal value for the selected direction: all ones up, all zeros down
  function automatic logic slice_at_end(input slice_t v, input logic dir_up);
    return dir_up ? (v == {SLICE_BITS{1'b1}}) : (v == '0);
  endfunction
endpackage

// File: rtl/updn_tc.sv
module updn_tc
  import updn_pkg::*;
(
  input  slice_t value,
  input  logic   up,
  input  logic   cin_n,
  output logic   at_end,
  output logic   cout_n
);
  always_comb begin
    at_end = slice_at_end(value, up);
    cout_n = ~(~cin_n & at_end);
  end
endmodule

// File: rtl/updn_slice.sv
module updn_slice
  import updn_pkg::*;
(
  input  logic   clk,
  input  logic   clear,
  input  logic   load,
  input  logic   cin_n,
  input  logic   up,
  input  slice_t jam,
  output slice_t q,
  output logic   at_end,
  output logic   cout_n
);
  slice_t q_r;
  logic   step_now;

  assign step_now = ~cin_n;

  // clear wins over load; both act without a clock edge
  always_ff @(posedge clk or posedge clear or posedge load) begin
    if (clear)         q_r <= '0;
    else if (load)     q_r <= jam;
    else if (step_now) q_r <= slice_step(q_r, up);
  end

  assign q = q_r;

  updn_tc u_tc (
    .value  (q_r),
    .up     (up),
    .cin_n  (cin_n),
    .at_end (at_end),
    .cout_n (cout_n)
  );
endmodule

// File: rtl/updn_cascade.sv
module updn_cascade
  import updn_pkg::*;
#(
  parameter int STAGES = 3
) (
  input  logic                           clk,
  input  logic                           clear,
  input  logic                           load,
  input  logic                           cin_n,
  input  logic                           up,
  input  logic [STAGES*SLICE_BITS-1:0]   jam,
  output logic [STAGES*SLICE_BITS-1:0]   count,
  output logic                           cout_n
);
  localparam int CW = STAGES * SLICE_BITS;

  logic [STAGES:0]   carry_n;
  logic [STAGES-1:0] slice_end;

  assign carry_n[0] = cin_n;

  for (genvar s = 0; s < STAGES; s++) begin : g_slice
    slice_t q_s;
    updn_slice u_slice (
      .clk    (clk),
      .clear  (clear),
      .load   (load),
      .cin_n  (carry_n[s]),
      .up     (up),
      .jam    (jam[s*SLICE_BITS +: SLICE_BITS]),
      .q      (q_s),
      .at_end (slice_end[s]),
      .cout_n (carry_n[s+1])
    );
    assign count[s*SLICE_BITS +: SLICE_BITS] = q_s;
  end

  assign cout_n = carry_n[STAGES];
endmodule

// File: rtl/updn_cascade_chk.sv
module updn_cascade_chk #(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          clear,
  input logic          load,
  input logic          cin_n,
  input logic          up,
  input logic [CW-1:0] jam,
  input logic [CW-1:0] count,
  input logic          cout_n
);
  // set when clear or load rose since the previous clock edge
  logic async_evt;
  always_ff @(posedge clk or posedge clear or posedge load) begin
    if (clear || load) async_evt <= 1'b1;
    else               async_evt <= 1'b0;
  end

  assert_clear_zero_R1: assert property (@(posedge clk)
    clear |-> count == '0);

  assert_load_jam_R2: assert property (@(posedge clk) disable iff (clear)
    load |-> count == jam);

  assert_hold_R3: assert property (@(posedge clk) disable iff (clear)
    (!async_evt && !load && !$past(load) && !$past(clear) && $past(cin_n))
    |-> count == $past(count));

  // R8: the step spans all slices, so carries must cross in one edge
  assert_count_up_R4: assert property (@(posedge clk) disable iff (clear)
    (!async_evt && !load && !$past(load) && !$past(clear) && !$past(cin_n) && $past(up))
    |-> count == CW'($past(count) + 1'b1));

  assert_count_down_R5: assert property (@(posedge clk) disable iff (clear)
    (!async_evt && !load && !$past(load) && !$past(clear) && !$past(cin_n) && !$past(up))
    |-> count == CW'($past(count) - 1'b1));

  assert_carry_out_R7: assert property (@(posedge clk) disable iff (clear)
    cout_n == !(!cin_n && (up ? (&count) : !(|count))));
endmodule

bind updn_cascade updn_cascade_chk #(.CW(CW)) u_chk (
  .clk    (clk),
  .clear  (clear),
  .load   (load),
  .cin_n  (cin_n),
  .up     (up),
  .jam    (jam),
  .count  (count),
  .cout_n (cout_n)
);

// File: tb/tb_updn_cascade.sv
`timescale 1ns/1ps
module tb_updn_cascade;
  localparam int PERIOD = 10;
  localparam int STAGES = 3;
  localparam int CW     = STAGES * 4;
  localparam int MOD    = 1 << CW;

  logic          clk = 1'b0;
  logic          clear, load, cin_n, up;
  logic [CW-1:0] jam;
  logic [CW-1:0] count;
  logic          cout_n;

  int    checks = 0;
  int    errors = 0;
  int    model  = 0;
  bit    armed  = 0;
  string tag    = "R1";

  updn_cascade #(.STAGES(STAGES)) dut (
    .clk(clk), .clear(clear), .load(load), .cin_n(cin_n), .up(up),
    .jam(jam), .count(count), .cout_n(cout_n)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_cout();
    bit term;
    term = up ? (model == MOD - 1) : (model == 0);
    return (!cin_n && term) ? 0 : 1;
  endfunction

  // one rising edge, with the model stepped from the inputs held there
  task automatic tick();
    @(posedge clk);
    if (clear)       model = 0;
    else if (load)   model = int'(jam);
    else if (!cin_n) model = up ? (model + 1) % MOD : (model + MOD - 1) % MOD;
    #2;
  endtask

  task automatic run(input logic c, input logic u, input int n);
    cin_n = c; up = u;
    for (int i = 0; i < n; i++) tick();
  endtask

  // mid-cycle load pulse, released before the next edge
  task automatic preset(input int v);
    jam = CW'(v); load = 1'b1; model = v;
    #1 chk(int'(count) == v, "R2", int'(count), v);
    #4 load = 1'b0;
    tick();
  endtask

  always @(negedge clk) begin
    if (armed) begin
      chk(int'(count) == model, tag, int'(count), model);
      chk(int'(cout_n) == exp_cout(), "R7", int'(cout_n), exp_cout());
    end
  end

  initial begin
    clear = 1'b1; load = 1'b0; cin_n = 1'b0; up = 1'b1; jam = '0;
    tick(); tick();
    armed = 1;
    chk(count == '0, "R1", int'(count), 0);
    #4 clear = 1'b0;
    tick();

    tag = "R4"; run(0, 1, 20);
    tag = "R3"; run(1, 1, 5); run(1, 0, 3);

    tag = "R8"; cin_n = 1'b1; preset('h0FD); run(0, 1, 5);
    tag = "R8"; cin_n = 1'b1; preset('h102); run(0, 0, 5);
    tag = "R6"; cin_n = 1'b1; preset('hFFD); run(0, 1, 5);
    tag = "R6"; cin_n = 1'b1; preset('h002); run(0, 0, 5);
    tag = "R5"; run(0, 0, 20);
    tag = "R6"; cin_n = 1'b1; preset('h10F); run(0, 1, 2); run(0, 0, 3);

    // direction flips while at terminal count
    tag = "R7"; cin_n = 1'b1; up = 1'b1; preset('hFFF);
    cin_n = 1'b0; up = 1'b1;
    #1 chk(cout_n == 1'b0, "R7", int'(cout_n), 0);
    up = 1'b0;
    #1 chk(cout_n == 1'b1, "R7", int'(cout_n), 1);
    cin_n = 1'b1;
    #1 chk(cout_n == 1'b1, "R7", int'(cout_n), 1);
    tick();
    tag = "R7"; preset('h000);
    cin_n = 1'b0; up = 1'b0;
    #1 chk(cout_n == 1'b0, "R7", int'(cout_n), 0);
    up = 1'b1;
    #1 chk(cout_n == 1'b1, "R7", int'(cout_n), 1);
    cin_n = 1'b1;
    tick();

    // clear overrides a simultaneous load, mid-cycle
    tag = "R1"; run(0, 1, 3);
    jam = 'hABC; load = 1'b1; clear = 1'b1; model = 0;
    #1 chk(count == '0, "R1", int'(count), 0);
    #4 load = 1'b0; clear = 1'b0;
    tick();
    // clear held across edges while counting is enabled
    clear = 1'b1; model = 0;
    #1 chk(count == '0, "R1", int'(count), 0);
    cin_n = 1'b0; up = 1'b1;
    tick(); tick();
    clear = 1'b0;
    tag = "R4"; run(0, 1, 3);

    // load held across a counting edge
    tag = "R2"; jam = 'h123; load = 1'b1; model = 'h123; cin_n = 1'b0; up = 1'b1;
    tick(); tick();
    chk(int'(count) == 'h123, "R2", int'(count), 'h123);
    #4 load = 1'b0;
    tag = "R4"; tick(); run(0, 1, 2);

    armed = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule